// File: doc/BRIEF.md
# Doorbell Mailbox Register Interface

This block is a memory-mapped command mailbox. A host writes a command word and an input payload, then sets a doorbell bit. The block freezes the command and hands the command-set byte, the command byte, the input length and a captured copy of the input payload to an external handler. It then waits for the handler's completion strobe. It writes the handler's result back into the status and command registers, and clears the doorbell so the host can see that the command is done.

The host bus is a single-beat request port. Accesses are 1, 2, 4 or 8 bytes wide and aligned to their own width. Reads return data one cycle after the request. The register window starts at offset 0: a capability word at 0x00, the control word at 0x04, the command register at 0x08, the status register at 0x10 and the background-status register at 0x18. The payload buffer starts at 0x20 and holds `2**PL_LOG2` bytes. Background progress (opcode, percent complete, return code) comes in on side inputs and is folded into the background-status word when that word is read.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset the control, command and status registers read zero and busy is low. The capability word reads the payload size exponent in bits [4:0], a 1 in bit 6 (background interrupt capable) and the configured vector number in bits [10:7]. All its other bits are zero.
- R2: A 4-byte write of bit 0 = 1 to the control word sets busy from the next cycle on. One cycle later `hnd_start` pulses for exactly one cycle. The command register layout is: command byte in bits [7:0], command-set byte in bits [15:8], length in bits [36:16]. While `hnd_start` is high, `hnd_set`, `hnd_op` and `hnd_len` carry those three fields.
- R3: On launch the whole payload buffer is zeroed. The handler reads, through `hnd_rd_idx`/`hnd_rd_byte`, the bytes the buffer held just before launch.
- R4: The handler's `hnd_done` (honoured only while a command is in flight) clears the doorbell and busy. It rewrites the command register with the same command set and command and with `hnd_len_out` as the length. It sets the status register to `hnd_rc` in bits [47:32] and `hnd_bg` in bit 0, with all other bits zero.
- R5: Writes to the status register are ignored. Of the 8-byte writes, only the command and background-status offsets change state. 8-byte writes at any other offset, and 1- or 2-byte writes below 0x20, are ignored.
- R6: Of the 4-byte writes below 0x20, only the capability and control offsets store data. Any other 4-byte offset is ignored.
- R7: Writes at 0x20 and above store 1 to 8 bytes, little-endian, into the payload buffer. They never launch a command.
- R8: An 8-byte read of the background-status offset returns the background opcode in [15:0], percent complete in [22:16] and return code in [47:32]. That word is also kept as the register's stored value.
- R9: An 8-byte read of the status register while percent complete is nonzero returns bit 0 cleared and keeps it cleared. While percent complete is zero, the flag is returned and kept unchanged.
- R10: While busy, every host write is ignored. This covers the control word (so a second ring launches nothing), the command register and the payload buffer.
- R11: If the input length exceeds the payload size, no handler start occurs and busy lasts one cycle. The status register then reads return code 0x0002 in [47:32] with bit 0 clear, the command register keeps its set and command with a length of zero, and the payload is left untouched.
- R12: `rvalid` rises one cycle after a read request. Narrow reads return the addressed bytes shifted down to bit 0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access width: 0=1B, 1=2B, 2=4B, 3=8B |
| addr | input | PL_LOG2+2 | Byte offset, aligned to the width |
| wdata | input | 64 | Write data, low bytes used |
| rvalid | output | 1 | Read data valid |
| rdata | output | 64 | Read data |
| busy | output | 1 | Doorbell set, command pending or in flight |
| hnd_start | output | 1 | One-cycle start to the handler |
| hnd_set | output | 8 | Command-set byte |
| hnd_op | output | 8 | Command byte |
| hnd_len | output | 21 | Input length in bytes |
| hnd_rd_idx | input | PL_LOG2 | Captured-input byte index |
| hnd_rd_byte | output | 8 | Captured-input byte |
| hnd_wr_en | input | 1 | Handler writes one output byte |
| hnd_wr_idx | input | PL_LOG2 | Output byte index |
| hnd_wr_byte | input | 8 | Output byte value |
| hnd_done | input | 1 | Handler completion strobe |
| hnd_rc | input | 16 | Return code |
| hnd_len_out | input | 21 | Output length in bytes |
| hnd_bg | input | 1 | Handler started a background task |
| bg_op | input | 16 | Current background opcode |
| bg_pct | input | 7 | Background percent complete |
| bg_rc | input | 16 | Background return code |

## Verification
A corrupted sequencer state shows up within a cycle or two of the ring. It appears as a missing or doubled `hnd_start`, or as busy staying high, and the bench counts starts and bounds the wait for busy to fall. A clear that misses part of the buffer stays hidden until completion. After completion, payload words beyond the handler's output read back as stale bytes instead of zero. Bad write protection leaves altered command, status or payload contents. These become visible on the first read after the offending write, and the bench issues that read for every ignored-write case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    localparam int OFF_CAP  = 0;
    localparam int OFF_CTRL = 4;
    localparam int OFF_CMD  = 8;
    localparam int OFF_STS  = 16;
    localparam int OFF_BGS  = 24;
    localparam int OFF_PL   = 32;

    localparam int LEN_W = 21;
    localparam logic [15:0] RC_INTERNAL = 16'h0002;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       set;
        logic [7:0]       op;
    } cmd_t;

    function automatic logic [63:0] cmd_pack(cmd_t c);
        return {27'd0, c.len, c.set, c.op};
    endfunction

    function automatic cmd_t cmd_unpack(logic [63:0] w);
        cmd_t c;
        c.op  = w[7:0];
        c.set = w[15:8];
        c.len = w[36:16];
        return c;
    endfunction

    function automatic logic [63:0] sts_pack(logic bg, logic [15:0] rc);
        return {16'd0, rc, 31'd0, bg};
    endfunction

    function automatic logic [63:0] bgs_pack(logic [15:0] op, logic [6:0] pct, logic [15:0] rc);
        return {16'd0, rc, 9'd0, pct, op};
    endfunction

    function automatic logic [31:0] cap_pack(logic [4:0] log2sz, logic [3:0] vec);
        // type=0 [22:19], ready time=0 [18:11], vector [10:7], bg irq [6], size exp [4:0]
        return {9'd0, 4'd0, 8'd0, vec, 1'b1, 1'b0, log2sz};
    endfunction

    function automatic logic [63:0] size_mask(acc_size_e s);
        case (s)
            SZ_B:    return 64'h0000_0000_0000_00FF;
            SZ_H:    return 64'h0000_0000_0000_FFFF;
            SZ_W:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/mbx_payload.sv
module mbx_payload #(
    parameter int PL_LOG2 = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 host_we,
    input  logic [PL_LOG2-1:0]   host_idx,
    input  logic [3:0]           host_nb,
    input  logic [63:0]          host_wdata,
    input  logic                 hnd_we,
    input  logic [PL_LOG2-1:0]   hnd_idx,
    input  logic [7:0]           hnd_byte,
    input  logic [PL_LOG2-4:0]   rd_qidx,
    output logic [63:0]          rd_qword,
    input  logic [PL_LOG2-1:0]   snap_idx,
    output logic [7:0]           snap_byte
);
    localparam int PL_BYTES = 1 << PL_LOG2;
    localparam int IW1      = PL_LOG2 + 1;

    logic [8*PL_BYTES-1:0] data_flat;
    logic [8*PL_BYTES-1:0] snap_flat;

    for (genvar i = 0; i < PL_BYTES; i++) begin : g_byte
        logic [7:0]     data_q;
        logic [7:0]     snap_q;
        logic [IW1-1:0] lane;
        logic           hit;

        assign lane = IW1'(i) - {1'b0, host_idx};
        assign hit  = host_we && ({1'b0, host_idx} <= IW1'(i)) && (lane < IW1'(host_nb));

        always_ff @(posedge clk) begin
            if (rst || clr)
                data_q <= '0;
            else if (hnd_we && hnd_idx == PL_LOG2'(i))
                data_q <= hnd_byte;
            else if (hit)
                data_q <= host_wdata[8*lane[2:0] +: 8];

            if (rst)
                snap_q <= '0;
            else if (clr)
                snap_q <= data_q;
        end

        assign data_flat[8*i +: 8] = data_q;
        assign snap_flat[8*i +: 8] = snap_q;
    end

    assign rd_qword  = data_flat[64*rd_qidx +: 64];
    assign snap_byte = snap_flat[8*snap_idx +: 8];

    assert_clear_full_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (data_flat[7:0] == 8'd0 && data_flat[8*PL_BYTES-1 -: 8] == 8'd0));

    assert_snapshot_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (snap_flat[8*PL_BYTES-1 -: 8] == $past(data_flat[8*PL_BYTES-1 -: 8])));

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic db,
    input  logic len_ok,
    input  logic hnd_done,
    output logic launch,
    output logic fin_ok,
    output logic fin_err,
    output logic waiting,
    output logic hnd_start
);
    seq_state_e state_q;

    always_comb begin
        waiting = (state_q == ST_WAIT);
        launch  = (state_q == ST_IDLE) && db && len_ok;
        fin_err = (state_q == ST_IDLE) && db && !len_ok;
        fin_ok  = waiting && hnd_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hnd_start <= 1'b0;
        end else begin
            hnd_start <= launch;
            if (launch)
                state_q <= ST_WAIT;
            else if (fin_ok)
                state_q <= ST_IDLE;
        end
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        hnd_start |=> !hnd_start);

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int PL_LOG2 = 6,
    parameter int MSI_VEC = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [1:0]           size,
    input  logic [PL_LOG2+1:0]   addr,
    input  logic [63:0]          wdata,
    output logic                 rvalid,
    output logic [63:0]          rdata,
    output logic                 busy,
    output logic                 hnd_start,
    output logic [7:0]           hnd_set,
    output logic [7:0]           hnd_op,
    output logic [LEN_W-1:0]     hnd_len,
    input  logic [PL_LOG2-1:0]   hnd_rd_idx,
    output logic [7:0]           hnd_rd_byte,
    input  logic                 hnd_wr_en,
    input  logic [PL_LOG2-1:0]   hnd_wr_idx,
    input  logic [7:0]           hnd_wr_byte,
    input  logic                 hnd_done,
    input  logic [15:0]          hnd_rc,
    input  logic [LEN_W-1:0]     hnd_len_out,
    input  logic                 hnd_bg,
    input  logic [15:0]          bg_op,
    input  logic [6:0]           bg_pct,
    input  logic [15:0]          bg_rc
);
    localparam int AW       = PL_LOG2 + 2;
    localparam int PL_BYTES = 1 << PL_LOG2;
    localparam logic [AW-1:0] A_CAP  = AW'(OFF_CAP);
    localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
    localparam logic [AW-1:0] A_CMD  = AW'(OFF_CMD);
    localparam logic [AW-1:0] A_STS  = AW'(OFF_STS);
    localparam logic [AW-1:0] A_BGS  = AW'(OFF_BGS);
    localparam logic [AW-1:0] A_PL   = AW'(OFF_PL);
    localparam logic [31:0]   CAP_RST = cap_pack(5'(PL_LOG2), 4'(MSI_VEC));

    logic [31:0] cap_q, ctrl_q;
    logic [63:0] cmd_q, sts_q, bgs_q;
    cmd_t        cmd_f;

    logic          wr_ok, is_pl, pl_in, w32, w64, rd_req, rd64;
    logic [AW-1:0] pl_off;
    logic          launch, fin_ok, fin_err, waiting, len_ok;
    logic [63:0]   pl_qword, bgs_live, sts_view, bgs_view, view, rd_val;

    // ---------------- decode ----------------
    always_comb begin
        cmd_f    = cmd_unpack(cmd_q);
        len_ok   = cmd_f.len <= LEN_W'(PL_BYTES);
        wr_ok    = req && we && !ctrl_q[0];
        rd_req   = req && !we;
        is_pl    = addr >= A_PL;
        pl_off   = addr - A_PL;
        pl_in    = is_pl && (pl_off < AW'(PL_BYTES));
        w32      = wr_ok && !is_pl && (size == SZ_W);
        w64      = wr_ok && !is_pl && (size == SZ_D);
        rd64     = rd_req && !is_pl && (size == SZ_D);
        bgs_live = bgs_pack(bg_op, bg_pct, bg_rc);
    end

    // ---------------- sequencer and payload ----------------
    mbx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .db        (ctrl_q[0]),
        .len_ok    (len_ok),
        .hnd_done  (hnd_done),
        .launch    (launch),
        .fin_ok    (fin_ok),
        .fin_err   (fin_err),
        .waiting   (waiting),
        .hnd_start (hnd_start)
    );

    mbx_payload #(.PL_LOG2(PL_LOG2)) u_pl (
        .clk        (clk),
        .rst        (rst),
        .clr        (launch),
        .host_we    (wr_ok && pl_in),
        .host_idx   (pl_off[PL_LOG2-1:0]),
        .host_nb    (4'd1 << size),
        .host_wdata (wdata),
        .hnd_we     (hnd_wr_en && waiting),
        .hnd_idx    (hnd_wr_idx),
        .hnd_byte   (hnd_wr_byte),
        .rd_qidx    (pl_off[PL_LOG2-1:3]),
        .rd_qword   (pl_qword),
        .snap_idx   (hnd_rd_idx),
        .snap_byte  (hnd_rd_byte)
    );

    // ---------------- register state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= CAP_RST;
            ctrl_q <= '0;
            cmd_q  <= '0;
            sts_q  <= '0;
            bgs_q  <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rd_val;
            if (w32 && addr == A_CAP)  cap_q  <= wdata[31:0];
            if (w32 && addr == A_CTRL) ctrl_q <= wdata[31:0];
            if (w64 && addr == A_CMD)  cmd_q  <= wdata;
            if (w64 && addr == A_BGS)  bgs_q  <= wdata;
            if (rd64 && addr == A_BGS) bgs_q  <= bgs_live;
            if (rd64 && addr == A_STS && bg_pct != 7'd0)
                sts_q[0] <= 1'b0;
            if (fin_ok) begin
                sts_q     <= sts_pack(hnd_bg, hnd_rc);
                cmd_q     <= cmd_pack('{len: hnd_len_out, set: cmd_f.set, op: cmd_f.op});
                ctrl_q[0] <= 1'b0;
            end
            if (fin_err) begin
                sts_q     <= sts_pack(1'b0, RC_INTERNAL);
                cmd_q     <= cmd_pack('{len: '0, set: cmd_f.set, op: cmd_f.op});
                ctrl_q[0] <= 1'b0;
            end
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        sts_view = sts_q;
        if (size == SZ_D && bg_pct != 7'd0)
            sts_view[0] = 1'b0;
        bgs_view = (size == SZ_D) ? bgs_live : bgs_q;
        if (is_pl)
            view = pl_in ? pl_qword : '0;
        else begin
            case (addr[4:3])
                2'd0:    view = {ctrl_q, cap_q};
                2'd1:    view = cmd_q;
                2'd2:    view = sts_view;
                default: view = bgs_view;
            endcase
        end
        rd_val = (view >> {addr[2:0], 3'b000}) & size_mask(acc_size_e'(size));
    end

    assign busy    = ctrl_q[0];
    assign hnd_set = cmd_f.set;
    assign hnd_op  = cmd_f.op;
    assign hnd_len = cmd_f.len;

    // ---------------- assertions ----------------
    assert_db_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[0]) |-> $past(fin_ok || fin_err));

    assert_cmd_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (waiting && !hnd_done) |=> $stable(cmd_q));

    assert_err_status_R11: assert property (@(posedge clk) disable iff (rst)
        fin_err |=> (sts_q[47:32] == RC_INTERNAL && !ctrl_q[0] && !waiting));

    assert_sts_ro_R5: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == A_STS && !fin_ok && !fin_err) |=> (sts_q[63:1] == $past(sts_q[63:1])));

endmodule

// File: tb/tb_mbx_doorbell.sv
module tb_mbx_doorbell;
    import mbx_pkg::*;

    localparam int PL_LOG2 = 6;
    localparam int AW      = PL_LOG2 + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1, req = 1'b0, we = 1'b0;
    logic [1:0]         size = 2'd0;
    logic [AW-1:0]      addr = '0;
    logic [63:0]        wdata = '0, rdata;
    logic               rvalid, busy, hnd_start;
    logic [7:0]         hnd_set, hnd_op, hnd_rd_byte;
    logic [LEN_W-1:0]   hnd_len;
    logic [PL_LOG2-1:0] hnd_rd_idx = '0, hnd_wr_idx = '0;
    logic               hnd_wr_en = 1'b0, hnd_done = 1'b0, hnd_bg = 1'b0;
    logic [7:0]         hnd_wr_byte = '0;
    logic [15:0]        hnd_rc = '0, bg_op = '0, bg_rc = '0;
    logic [LEN_W-1:0]   hnd_len_out = '0;
    logic [6:0]         bg_pct = '0;

    mbx_doorbell #(.PL_LOG2(PL_LOG2), .MSI_VEC(3)) dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .rvalid(rvalid), .rdata(rdata), .busy(busy),
        .hnd_start(hnd_start), .hnd_set(hnd_set), .hnd_op(hnd_op), .hnd_len(hnd_len),
        .hnd_rd_idx(hnd_rd_idx), .hnd_rd_byte(hnd_rd_byte), .hnd_wr_en(hnd_wr_en),
        .hnd_wr_idx(hnd_wr_idx), .hnd_wr_byte(hnd_wr_byte), .hnd_done(hnd_done),
        .hnd_rc(hnd_rc), .hnd_len_out(hnd_len_out), .hnd_bg(hnd_bg),
        .bg_op(bg_op), .bg_pct(bg_pct), .bg_rc(bg_rc)
    );

    int n_checks = 0, n_errs = 0, n_starts = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // handler stub configuration and observations
    int               stub_nout = 0, stub_delay = 0;
    logic [15:0]      stub_rc = '0;
    logic [LEN_W-1:0] stub_len_out = '0;
    logic             stub_bg = 1'b0;
    logic [7:0]       got_set, got_op;
    logic [LEN_W-1:0] got_len;
    logic [31:0]      got_snap;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int a, input acc_size_e sz, input logic [63:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = AW'(a); size = sz; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic hr(input int a, input acc_size_e sz, input logic [63:0] e, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = AW'(a); size = sz;
        exp_q.push_back('{val: e, tag: tag});
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 500; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check(!busy, tag, 64'(busy), 64'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0)
                check(1'b0, "R12 unexpected read data", rdata, 64'd0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rdata === e.val, e.tag, rdata, e.val);
            end
        end
    end

    // handler stub
    initial begin
        forever begin
            @(negedge clk);
            if (hnd_start) begin
                n_starts++;
                got_set = hnd_set; got_op = hnd_op; got_len = hnd_len;
                for (int k = 0; k < 4; k++) begin
                    hnd_rd_idx = PL_LOG2'(k);
                    #1;
                    got_snap[8*k +: 8] = hnd_rd_byte;
                end
                @(negedge clk);
                check(!hnd_start, "R2 start lasts one cycle", 64'(hnd_start), 64'd0);
                for (int k = 0; k < stub_nout; k++) begin
                    hnd_wr_en = 1'b1; hnd_wr_idx = PL_LOG2'(k); hnd_wr_byte = 8'(8'hA0 + k);
                    @(negedge clk);
                end
                hnd_wr_en = 1'b0;
                repeat (stub_delay) @(negedge clk);
                hnd_done = 1'b1; hnd_rc = stub_rc; hnd_len_out = stub_len_out; hnd_bg = stub_bg;
                @(negedge clk);
                hnd_done = 1'b0;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        hr(0,  SZ_D, 64'h0000_0000_0000_01C6, "R1 cap and ctrl reset");
        hr(8,  SZ_D, 64'd0, "R1 cmd reset");
        hr(16, SZ_D, 64'd0, "R1 sts reset");

        // R12 narrow reads
        hr(0, SZ_H, 64'h01C6, "R12 halfword read");
        hr(0, SZ_B, 64'hC6, "R12 byte read");

        // R7 payload writes
        hw(32, SZ_D, 64'h0807_0605_0403_0201);
        hw(42, SZ_H, 64'h0000_0000_0000_BBAA);
        hw(47, SZ_B, 64'h0000_0000_0000_00CC);
        check(busy == 1'b0, "R7 payload write does not launch", 64'(busy), 64'd0);
        hr(32, SZ_D, 64'h0807_0605_0403_0201, "R7 payload qword 0");
        hr(40, SZ_D, 64'hCC00_0000_BBAA_0000, "R7 payload qword 1");
        hr(34, SZ_H, 64'h0403, "R12 payload halfword");

        // R2 R3 R4 main command
        hw(8, SZ_D, 64'h0000_0000_0010_4A03);
        stub_nout = 4; stub_rc = 16'h0; stub_len_out = 4; stub_bg = 1'b0; stub_delay = 2;
        s0 = n_starts;
        hw(4, SZ_W, 64'd1);
        check(busy == 1'b1, "R2 busy after ring", 64'(busy), 64'd1);
        wait_idle("R4 completion clears busy");
        check(n_starts == s0 + 1, "R2 one handler start", 64'(n_starts - s0), 64'd1);
        check(got_set == 8'h4A, "R2 command set", 64'(got_set), 64'h4A);
        check(got_op == 8'h03, "R2 command", 64'(got_op), 64'h03);
        check(got_len == 16, "R2 input length", 64'(got_len), 64'd16);
        check(got_snap == 32'h0403_0201, "R3 captured input", 64'(got_snap), 64'h0403_0201);
        hr(8,  SZ_D, 64'h0000_0000_0004_4A03, "R4 cmd rewritten with output length");
        hr(16, SZ_D, 64'd0, "R4 status rebuilt");
        hr(4,  SZ_W, 64'd0, "R4 doorbell cleared");
        hr(32, SZ_D, 64'h0000_0000_A3A2_A1A0, "R3 cleared then handler output");
        hr(40, SZ_D, 64'd0, "R3 stale bytes cleared");

        // R4 R9 background flag
        hw(8, SZ_D, 64'h0000_0000_0000_0100);
        stub_nout = 0; stub_rc = 16'h0015; stub_len_out = 0; stub_bg = 1'b1; stub_delay = 0;
        hw(4, SZ_W, 64'd1);
        wait_idle("R4 completion with background");
        hr(8,  SZ_D, 64'h0000_0000_0000_0100, "R4 cmd with zero output length");
        hr(16, SZ_D, 64'h0000_0015_0000_0001, "R4 status bg and code");
        hr(16, SZ_D, 64'h0000_0015_0000_0001, "R9 flag kept while percent zero");
        bg_pct = 7'd10;
        hr(16, SZ_D, 64'h0000_0015_0000_0000, "R9 flag cleared by read");
        bg_pct = 7'd0;
        hr(16, SZ_D, 64'h0000_0015_0000_0000, "R9 flag stays cleared");

        // R8 background status
        bg_op = 16'h1234; bg_pct = 7'd50; bg_rc = 16'h0007;
        hr(24, SZ_D, 64'h0000_0007_0032_1234, "R8 composed background word");
        bg_pct = 7'd0;
        hr(24, SZ_W, 64'h0032_1234, "R8 composed word kept");

        // R5 R6 write protection
        hw(16, SZ_D, 64'hFFFF_FFFF_FFFF_FFFF);
        hr(16, SZ_D, 64'h0000_0015_0000_0000, "R5 status write ignored");
        hw(24, SZ_D, 64'h0000_0000_0000_0055);
        hr(24, SZ_W, 64'h55, "R5 background register writable");
        hw(8, SZ_W, 64'h0000_FFFF);
        hr(8, SZ_D, 64'h0000_0000_0000_0100, "R6 4-byte write at cmd ignored");
        hw(8, SZ_H, 64'h0000_FFFF);
        hr(8, SZ_D, 64'h0000_0000_0000_0100, "R5 2-byte write at cmd ignored");
        hw(0, SZ_D, 64'hFFFF_FFFF_FFFF_FFFF);
        check(busy == 1'b0, "R5 8-byte write at cap offset no ring", 64'(busy), 64'd0);
        hr(0, SZ_D, 64'h0000_0000_0000_01C6, "R5 8-byte write at cap ignored");
        hw(16, SZ_W, 64'h0000_ABCD);
        hr(16, SZ_D, 64'h0000_0015_0000_0000, "R6 4-byte write at status ignored");

        // R10 writes ignored while busy
        hw(8, SZ_D, 64'h0000_0000_0008_2211);
        stub_nout = 1; stub_rc = 16'h0; stub_len_out = 1; stub_bg = 1'b0; stub_delay = 20;
        s0 = n_starts;
        hw(4, SZ_W, 64'd1);
        hw(8, SZ_D, 64'h0000_0000_0000_9999);
        hw(48, SZ_D, 64'hFFFF_FFFF_FFFF_FFFF);
        hw(4, SZ_W, 64'd1);
        hw(4, SZ_W, 64'd0);
        check(busy == 1'b1, "R10 control write ignored while busy", 64'(busy), 64'd1);
        wait_idle("R10 completion");
        repeat (4) @(negedge clk);
        check(n_starts == s0 + 1, "R10 second ring launches nothing", 64'(n_starts - s0), 64'd1);
        hr(8,  SZ_D, 64'h0000_0000_0001_2211, "R10 cmd write ignored while busy");
        hr(48, SZ_D, 64'd0, "R10 payload write ignored while busy");

        // R11 oversize length
        hw(8, SZ_D, 64'h0000_0000_0064_0705);
        s0 = n_starts;
        hw(4, SZ_W, 64'd1);
        check(busy == 1'b1, "R11 busy set", 64'(busy), 64'd1);
        @(negedge clk);
        check(busy == 1'b0, "R11 busy lasts one cycle", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        check(n_starts == s0, "R11 handler not started", 64'(n_starts - s0), 64'd0);
        hr(16, SZ_D, 64'h0000_0002_0000_0000, "R11 internal error code");
        hr(8,  SZ_D, 64'h0000_0000_0000_0705, "R11 length zero");
        hr(32, SZ_D, 64'h0000_0000_0000_00A0, "R11 payload untouched");

        // R6 capability write stored
        hw(0, SZ_W, 64'h0000_1234);
        hr(0, SZ_W, 64'h0000_1234, "R6 capability word stored");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R12 all reads answered", 64'(exp_q.size()), 64'd0);
        summary();
    end

endmodule